// File: doc/BRIEF.md
# Reorder Buffer Retire Control

This block keeps the retire-order bookkeeping for an out-of-order core. It holds a circular queue of `DEPTH` slots. At dispatch, each instruction claims a run of consecutive slots sized by its micro-op count. The block hands back a token, which is the index of the first slot in that run. Later the execution side returns that token to mark the instruction as executed.

The oldest live instruction is shown on the head outputs. While the head is executed, the block retires it in the same cycle. The head pointer then jumps past that instruction's slots, and the slots become free again. One cycle can retire several instructions, back to back, up to a configured limit.

Dispatch uses the free slot count to decide when to stall. Four error outputs flag illegal requests, and each illegal request is dropped. Instruction payloads are reduced to a small tag.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After reset, `free_o` equals `DEPTH`, `rsv_token_o` is 0 and `head_valid_o` is 0.
- R2: A reservation claims a number of slots equal to its micro-op count limited to at most `DEPTH`. A count of 0 claims exactly one slot.
- R3: `rsv_token_o` shows the allocation pointer before it moves. An accepted reservation moves the pointer forward by the claimed slot count, wrapping modulo `DEPTH`.
- R4: An accepted reservation lowers `free_o` by its claimed slot count on the next cycle, and `free_o` never exceeds `DEPTH`.
- R5: A reservation is accepted only if it claims no more slots than `free_o` showed at the start of the cycle. Otherwise `err_oversub_o` is 1 in that cycle and the reservation changes nothing.
- R6: A legal completion marks its entry as executed. If that entry is the head, `head_done_o` rises on the next cycle.
- R7: A completion whose token is `DEPTH` or more raises `err_range_o` in that cycle and has no effect.
- R8: A completion whose token is not the first slot of a live entry raises `err_unalloc_o` in that cycle and has no effect.
- R9: A completion on an entry that is already executed raises `err_double_o` in that cycle.
- R10: Retirement is strictly in order, and an executed head retires in the same cycle.
  - `retire_cnt_o` reports the number of entries retired in the cycle.
  - Each retired entry moves the head forward by its slot count, modulo `DEPTH`, and returns that count to `free_o` on the next cycle.
  - Retirement stops at the first entry that is not executed.
- R11: At most `RETIRE_MAX` entries retire per cycle. `RETIRE_MAX` = 0 means there is no limit.
- R12: When a reservation and a retirement happen in the same cycle, both changes apply to `free_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_valid_i | input | 1 | Reservation request |
| rsv_uops_i | input | UOP_W | Micro-op count of the instruction |
| rsv_tag_i | input | TAG_W | Tag stored with the entry |
| rsv_token_o | output | PTR_W | Token given to the current reservation |
| done_valid_i | input | 1 | Completion request |
| done_token_i | input | PTR_W+1 | Token of the completed instruction |
| free_o | output | CNT_W | Free slot count |
| head_valid_o | output | 1 | Head entry is live |
| head_done_o | output | 1 | Head entry is executed |
| head_tag_o | output | TAG_W | Tag of the head entry |
| head_token_o | output | PTR_W | Slot index of the head entry |
| retire_cnt_o | output | CNT_W | Entries retired in this cycle |
| err_oversub_o | output | 1 | Reservation rejected: not enough free slots |
| err_range_o | output | 1 | Completion token out of range |
| err_unalloc_o | output | 1 | Completion on an entry that is not live |
| err_double_o | output | 1 | Completion on an entry that is already executed |

## Verification
The main instance is built with `DEPTH` = 6, which is not a power of two. This makes pointer wrap a true modulo operation. It also leaves token codes 6 to 15 on the four-bit completion port, so out-of-range tokens can be driven. A micro-op width of four bits allows counts above the depth, which exercises the clamp.

The retire limit is 2, so a run of three executed entries shows the limit taking effect. A second instance with a limit of 0 receives the same stimulus, and that run shows the unlimited mode draining all three in one cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
    // Outcome of checking one completion request
    typedef struct packed {
        logic apply;
        logic out_of_range;
        logic not_live;
        logic twice;
    } done_chk_t;
endpackage

// File: rtl/rob_slot_norm.sv
module rob_slot_norm #(
    parameter int DEPTH = 8,
    parameter int UOP_W = 4,
    parameter int CNT_W = 4
) (
    input  logic [UOP_W-1:0] uops_i,
    output logic [CNT_W-1:0] slots_o
);
    logic [31:0] wide;

    always_comb begin
        wide = 32'(uops_i);
        if (wide == 32'd0) begin
            slots_o = CNT_W'(1);
        end else if (wide > 32'(DEPTH)) begin
            slots_o = CNT_W'(DEPTH);
        end else begin
            slots_o = CNT_W'(wide);
        end
    end
endmodule

// File: rtl/rob_done_check.sv
module rob_done_check
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int TOK_W = 4
) (
    input  logic             valid_i,
    input  logic [TOK_W-1:0] token_i,
    input  logic [DEPTH-1:0] live_i,
    input  logic [DEPTH-1:0] exec_i,
    output done_chk_t        chk_o,
    output logic [PTR_W-1:0] idx_o
);
    logic in_range;
    logic hit_live;
    logic hit_exec;

    always_comb begin
        in_range = 32'(token_i) < 32'(DEPTH);
        hit_live = 1'b0;
        hit_exec = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (token_i == TOK_W'(i)) begin
                hit_live = live_i[i];
                hit_exec = exec_i[i];
            end
        end
        chk_o.out_of_range = valid_i && !in_range;
        chk_o.not_live     = valid_i && in_range && !hit_live;
        chk_o.twice        = valid_i && in_range && hit_live && hit_exec;
        chk_o.apply        = valid_i && in_range && hit_live && !hit_exec;
        idx_o              = PTR_W'(token_i);
    end
endmodule

// File: rtl/rob_retire_walk.sv
module rob_retire_walk #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4,
    parameter int LIMIT = 2
) (
    input  logic [PTR_W-1:0]            head_i,
    input  logic [DEPTH-1:0]            live_i,
    input  logic [DEPTH-1:0]            exec_i,
    input  logic [DEPTH-1:0][CNT_W-1:0] slots_i,
    output logic [PTR_W-1:0]            head_o,
    output logic [CNT_W-1:0]            freed_o,
    output logic [CNT_W-1:0]            count_o,
    output logic [DEPTH-1:0]            clear_o
);
    localparam int LIM_EFF = (LIMIT == 0 || LIMIT > DEPTH) ? DEPTH : LIMIT;

    logic [PTR_W-1:0] h;
    logic [CNT_W:0]   nxt;
    logic             go;

    always_comb begin
        h       = head_i;
        freed_o = '0;
        count_o = '0;
        clear_o = '0;
        go      = 1'b1;
        nxt     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (go && (count_o < CNT_W'(LIM_EFF)) && live_i[h] && !clear_o[h] && exec_i[h]) begin
                clear_o[h] = 1'b1;
                freed_o    = freed_o + slots_i[h];
                count_o    = count_o + 1'b1;
                nxt        = (CNT_W+1)'(h) + (CNT_W+1)'(slots_i[h]);
                if (nxt >= (CNT_W+1)'(DEPTH)) begin
                    nxt = nxt - (CNT_W+1)'(DEPTH);
                end
                h = PTR_W'(nxt);
            end else begin
                go = 1'b0;
            end
        end
        head_o = h;
    end
endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int TAG_W      = 4,
    parameter int UOP_W      = 4,
    parameter int RETIRE_MAX = 2,
    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int TOK_W     = PTR_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rsv_valid_i,
    input  logic [UOP_W-1:0] rsv_uops_i,
    input  logic [TAG_W-1:0] rsv_tag_i,
    output logic [PTR_W-1:0] rsv_token_o,
    input  logic             done_valid_i,
    input  logic [TOK_W-1:0] done_token_i,
    output logic [CNT_W-1:0] free_o,
    output logic             head_valid_o,
    output logic             head_done_o,
    output logic [TAG_W-1:0] head_tag_o,
    output logic [PTR_W-1:0] head_token_o,
    output logic [CNT_W-1:0] retire_cnt_o,
    output logic             err_oversub_o,
    output logic             err_range_o,
    output logic             err_unalloc_o,
    output logic             err_double_o
);
    typedef struct packed {
        logic [PTR_W-1:0]            alloc;
        logic [PTR_W-1:0]            head;
        logic [CNT_W-1:0]            free;
        logic [DEPTH-1:0]            live;
        logic [DEPTH-1:0]            exec;
        logic [DEPTH-1:0][CNT_W-1:0] slots;
        logic [DEPTH-1:0][TAG_W-1:0] tags;
    } rob_state_t;

    rob_state_t s_q, s_d;

    logic [CNT_W-1:0] norm_slots;
    done_chk_t        chk;
    logic [PTR_W-1:0] chk_idx;
    logic [PTR_W-1:0] walk_head;
    logic [CNT_W-1:0] walk_freed;
    logic [CNT_W-1:0] walk_count;
    logic [DEPTH-1:0] walk_clear;
    logic             accept;
    logic [CNT_W:0]   alloc_sum;
    logic [CNT_W+1:0] free_sum;

    rob_slot_norm #(
        .DEPTH (DEPTH),
        .UOP_W (UOP_W),
        .CNT_W (CNT_W)
    ) u_norm (
        .uops_i  (rsv_uops_i),
        .slots_o (norm_slots)
    );

    rob_done_check #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .TOK_W (TOK_W)
    ) u_done (
        .valid_i (done_valid_i),
        .token_i (done_token_i),
        .live_i  (s_q.live),
        .exec_i  (s_q.exec),
        .chk_o   (chk),
        .idx_o   (chk_idx)
    );

    rob_retire_walk #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W),
        .LIMIT (RETIRE_MAX)
    ) u_walk (
        .head_i  (s_q.head),
        .live_i  (s_q.live),
        .exec_i  (s_q.exec),
        .slots_i (s_q.slots),
        .head_o  (walk_head),
        .freed_o (walk_freed),
        .count_o (walk_count),
        .clear_o (walk_clear)
    );

    always_comb begin
        s_d       = s_q;
        accept    = rsv_valid_i && (s_q.free >= norm_slots);
        alloc_sum = (CNT_W+1)'(s_q.alloc) + (CNT_W+1)'(norm_slots);
        if (alloc_sum >= (CNT_W+1)'(DEPTH)) begin
            alloc_sum = alloc_sum - (CNT_W+1)'(DEPTH);
        end

        // retirement frees entries that were executed at cycle start
        s_d.live = s_q.live & ~walk_clear;
        s_d.exec = s_q.exec & ~walk_clear;
        s_d.head = walk_head;

        if (accept) begin
            s_d.live[s_q.alloc]  = 1'b1;
            s_d.exec[s_q.alloc]  = 1'b0;
            s_d.slots[s_q.alloc] = norm_slots;
            s_d.tags[s_q.alloc]  = rsv_tag_i;
            s_d.alloc            = PTR_W'(alloc_sum);
        end

        if (chk.apply) begin
            s_d.exec[chk_idx] = 1'b1;
        end

        free_sum = (CNT_W+2)'(s_q.free) + (CNT_W+2)'(walk_freed)
                 - (accept ? (CNT_W+2)'(norm_slots) : '0);
        s_d.free = CNT_W'(free_sum);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.free  <= CNT_W'(DEPTH);
        end else begin
            s_q <= s_d;
        end
    end

    assign rsv_token_o   = s_q.alloc;
    assign free_o        = s_q.free;
    assign head_valid_o  = s_q.live[s_q.head];
    assign head_done_o   = s_q.live[s_q.head] && s_q.exec[s_q.head];
    assign head_tag_o    = s_q.tags[s_q.head];
    assign head_token_o  = s_q.head;
    assign retire_cnt_o  = walk_count;
    assign err_oversub_o = rsv_valid_i && !accept;
    assign err_range_o   = chk.out_of_range;
    assign err_unalloc_o = chk.not_live;
    assign err_double_o  = chk.twice;
endmodule

// File: rtl/rob_retire_ctrl_chk.sv
module rob_retire_ctrl_chk #(
    parameter int DEPTH      = 8,
    parameter int RETIRE_MAX = 2,
    parameter int CNT_W      = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rsv_valid_i,
    input logic             done_valid_i,
    input logic [CNT_W-1:0] free_o,
    input logic             head_valid_o,
    input logic             head_done_o,
    input logic [CNT_W-1:0] retire_cnt_o,
    input logic             err_oversub_o,
    input logic             err_range_o,
    input logic             err_unalloc_o,
    input logic             err_double_o
);
    localparam int LIM = (RETIRE_MAX == 0 || RETIRE_MAX > DEPTH) ? DEPTH : RETIRE_MAX;

    assert_free_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        free_o <= CNT_W'(DEPTH));

    assert_empty_head_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_o == CNT_W'(DEPTH)) |-> !head_valid_o);

    assert_oversub_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_oversub_o && retire_cnt_o == '0) |=> $stable(free_o));

    assert_oversub_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_oversub_o |-> rsv_valid_i);

    assert_range_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_range_o || err_unalloc_o || err_double_o) |-> done_valid_i);

    assert_err_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({err_range_o, err_unalloc_o, err_double_o}));

    assert_in_order_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !head_done_o |-> (retire_cnt_o == '0));

    assert_free_return_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire_cnt_o != '0 && !rsv_valid_i) |=> (free_o > $past(free_o)));

    assert_retire_cap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_cnt_o <= CNT_W'(LIM));
endmodule

bind rob_retire_ctrl rob_retire_ctrl_chk #(
    .DEPTH      (DEPTH),
    .RETIRE_MAX (RETIRE_MAX),
    .CNT_W      (CNT_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rsv_valid_i   (rsv_valid_i),
    .done_valid_i  (done_valid_i),
    .free_o        (free_o),
    .head_valid_o  (head_valid_o),
    .head_done_o   (head_done_o),
    .retire_cnt_o  (retire_cnt_o),
    .err_oversub_o (err_oversub_o),
    .err_range_o   (err_range_o),
    .err_unalloc_o (err_unalloc_o),
    .err_double_o  (err_double_o)
);

// File: tb/test_rob_retire_ctrl.sv
module test_rob_retire_ctrl;
    localparam int DEPTH = 6;
    localparam int TAG_W = 4;
    localparam int UOP_W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rsv_valid = 1'b0;
    logic [3:0] rsv_uops = '0;
    logic [3:0] rsv_tag = '0;
    logic       done_valid = 1'b0;
    logic [3:0] done_token = '0;

    logic [2:0] tok, head_tok, u_tok, u_head_tok;
    logic [2:0] free, retire_cnt, u_free, u_retire_cnt;
    logic [3:0] head_tag, u_head_tag;
    logic head_valid, head_done, e_over, e_range, e_unalloc, e_double;
    logic u_head_valid, u_head_done, u_over, u_range, u_unalloc, u_double;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rob_retire_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .UOP_W(UOP_W), .RETIRE_MAX(2)) i_rob_retire_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .rsv_valid_i(rsv_valid), .rsv_uops_i(rsv_uops),
        .rsv_tag_i(rsv_tag), .rsv_token_o(tok), .done_valid_i(done_valid),
        .done_token_i(done_token), .free_o(free), .head_valid_o(head_valid),
        .head_done_o(head_done), .head_tag_o(head_tag), .head_token_o(head_tok),
        .retire_cnt_o(retire_cnt), .err_oversub_o(e_over), .err_range_o(e_range),
        .err_unalloc_o(e_unalloc), .err_double_o(e_double));

    rob_retire_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .UOP_W(UOP_W), .RETIRE_MAX(0)) i_rob_unl (
        .clk_i(clk), .rst_ni(rst_n), .rsv_valid_i(rsv_valid), .rsv_uops_i(rsv_uops),
        .rsv_tag_i(rsv_tag), .rsv_token_o(u_tok), .done_valid_i(done_valid),
        .done_token_i(done_token), .free_o(u_free), .head_valid_o(u_head_valid),
        .head_done_o(u_head_done), .head_tag_o(u_head_tag), .head_token_o(u_head_tok),
        .retire_cnt_o(u_retire_cnt), .err_oversub_o(u_over), .err_range_o(u_range),
        .err_unalloc_o(u_unalloc), .err_double_o(u_double));

    typedef struct packed {
        logic       rv;
        logic [3:0] uops;
        logic [3:0] tag;
        logic       dv;
        logic [3:0] dtok;
        logic [2:0] etok;
        logic       eover;
        logic [2:0] eret;
        logic [2:0] efree;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd2, 4'd1, 1'b0, 4'd0, 3'd0, 1'b0, 3'd0, 3'd4},
        '{1'b1, 4'd0, 4'd2, 1'b0, 4'd0, 3'd2, 1'b0, 3'd0, 3'd3},
        '{1'b1, 4'd9, 4'd3, 1'b0, 4'd0, 3'd3, 1'b1, 3'd0, 3'd3},
        '{1'b0, 4'd0, 4'd0, 1'b1, 4'd2, 3'd3, 1'b0, 3'd0, 3'd3},
        '{1'b0, 4'd0, 4'd0, 1'b1, 4'd0, 3'd3, 1'b0, 3'd0, 3'd3},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 3'd3, 1'b0, 3'd2, 3'd6},
        '{1'b1, 4'd3, 4'd4, 1'b0, 4'd0, 3'd3, 1'b0, 3'd0, 3'd3},
        '{1'b1, 4'd3, 4'd5, 1'b0, 4'd0, 3'd0, 1'b0, 3'd0, 3'd0},
        '{1'b1, 4'd1, 4'd6, 1'b0, 4'd0, 3'd3, 1'b1, 3'd0, 3'd0},
        '{1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 3'd3, 1'b0, 3'd0, 3'd0},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 3'd3, 1'b0, 3'd1, 3'd3},
        '{1'b1, 4'd2, 4'd7, 1'b1, 4'd0, 3'd3, 1'b0, 3'd0, 3'd1},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 3'd5, 1'b0, 3'd1, 3'd4},
        '{1'b1, 4'd1, 4'd8, 1'b1, 4'd3, 3'd5, 1'b0, 3'd0, 3'd3},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 3'd0, 1'b0, 3'd1, 3'd5}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; comb outputs valid 1 ns later
    task automatic drive(input logic rv, input int uops, input int tag,
                         input logic dv, input int dtok);
        rsv_valid  = rv;
        rsv_uops   = 4'(uops);
        rsv_tag    = 4'(tag);
        done_valid = dv;
        done_token = 4'(dtok);
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
        rsv_valid  = 1'b0;
        done_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 free", int'(free), DEPTH);
        chk("R1 token", int'(tok), 0);
        chk("R1 head_valid", int'(head_valid), 0);

        // table walk: R2 R3 R4 R5 R6 R10 R12
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].rv, int'(VEC[i].uops), int'(VEC[i].tag), VEC[i].dv, int'(VEC[i].dtok));
            chk($sformatf("R3 token v%0d", i), int'(tok), int'(VEC[i].etok));
            chk($sformatf("R5 oversub v%0d", i), int'(e_over), int'(VEC[i].eover));
            chk($sformatf("R10 retire v%0d", i), int'(retire_cnt), int'(VEC[i].eret));
            tick();
            chk($sformatf("R4 free v%0d", i), int'(free), int'(VEC[i].efree));
        end

        // state: head 5 (tag 8, not executed), alloc 0, free 5
        chk("R10 head_tag", int'(head_tag), 8);
        chk("R10 head_token", int'(head_tok), 5);
        chk("R10 head_valid", int'(head_valid), 1);

        drive(1'b0, 0, 0, 1'b1, 7);
        chk("R7 range", int'(e_range), 1);
        tick();
        chk("R7 no effect free", int'(free), 5);
        chk("R7 no effect done", int'(head_done), 0);

        drive(1'b0, 0, 0, 1'b1, 1);
        chk("R8 unalloc", int'(e_unalloc), 1);
        tick();
        chk("R8 no effect done", int'(head_done), 0);
        chk("R8 no effect free", int'(free), 5);

        drive(1'b0, 0, 0, 1'b1, 5);
        chk("R6 no error", int'(e_range | e_unalloc | e_double), 0);
        tick();
        chk("R6 head_done", int'(head_done), 1);

        drive(1'b0, 0, 0, 1'b1, 5);
        chk("R9 double", int'(e_double), 1);
        chk("R10 retire head", int'(retire_cnt), 1);
        tick();
        chk("R10 free back", int'(free), 6);
        chk("R10 head wrap", int'(head_tok), 0);
        chk("R10 empty", int'(head_valid), 0);

        // clamp and full-queue wrap
        do_reset();
        chk("R1 free after reset", int'(free), DEPTH);
        drive(1'b1, 15, 9, 1'b0, 0);
        chk("R2 clamp accepted", int'(e_over), 0);
        chk("R3 clamp token", int'(tok), 0);
        tick();
        chk("R2 clamp free", int'(free), 0);
        chk("R3 alloc wraps", int'(tok), 0);
        drive(1'b1, 0, 2, 1'b0, 0);
        chk("R2 zero uop needs one slot", int'(e_over), 1);
        tick();
        chk("R5 free unchanged", int'(free), 0);
        drive(1'b0, 0, 0, 1'b1, 0);
        tick();
        drive(1'b0, 0, 0, 1'b0, 0);
        chk("R10 full retire", int'(retire_cnt), 1);
        tick();
        chk("R10 full free", int'(free), 6);

        // retire limit vs unlimited
        do_reset();
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1, i + 1, 1'b0, 0);
            tick();
        end
        for (int i = 2; i >= 0; i--) begin
            drive(1'b0, 0, 0, 1'b1, i);
            tick();
        end
        drive(1'b0, 0, 0, 1'b0, 0);
        chk("R11 limited", int'(retire_cnt), 2);
        chk("R11 unlimited", int'(u_retire_cnt), 3);
        tick();
        chk("R11 limited free", int'(free), 5);
        chk("R11 unlimited free", int'(u_free), 6);
        drive(1'b0, 0, 0, 1'b0, 0);
        chk("R11 remainder", int'(retire_cnt), 1);
        tick();

        // same-cycle reserve and retire
        do_reset();
        drive(1'b1, 2, 1, 1'b0, 0);
        tick();
        drive(1'b0, 0, 0, 1'b1, 0);
        tick();
        drive(1'b1, 4, 2, 1'b0, 0);
        chk("R12 accepted", int'(e_over), 0);
        chk("R12 token", int'(tok), 2);
        chk("R12 retire", int'(retire_cnt), 1);
        tick();
        chk("R12 free", int'(free), 2);
        chk("R12 head", int'(head_tok), 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule